// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a simple request port and an asynchronous DRAM whose row and column addresses share one set of pins. A client presents a read or a write with a flat word address on a valid/ready handshake. The controller splits that address into a row part and a column part. It plays out the active-low strobe sequence on the device pins and returns read data with a one-cycle valid pulse. The device data pins are bidirectional. At the block edge they appear as a data-out vector, an output enable and a data-in vector.

After an access, the row stays open with the row strobe held low. A later request to the same row costs only a column-strobe cycle. A request to another row first raises the row strobe for a precharge interval, then opens the new row. A refresh scheduler raises a request at a fixed cycle interval. The controller serves that request between accesses with a row-only cycle. It walks the row addresses in sequence and closes any open row first. All device timings are whole clock-cycle counts set by parameters.

Top module: `pagedram_ctrl`

## Requirements
- R1: While reset is held and directly after it, all four strobes are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: The write strobe and the output-enable strobe are never low together. `dram_dq_oe` is high only while the write strobe and the column strobe are both low.
- R3: `req_addr` carries the row in its upper ROW_W bits and the column in its lower COL_W bits. On a closed row, the row strobe falls with the row on `dram_addr`, and the column strobe falls exactly T_RCD cycles later with the column on `dram_addr`.
- R4: A write drives the write strobe low, keeps output-enable high, and drives the request data on `dram_dq_out` with `dram_dq_oe` high while the column strobe is low.
- R5: A read drives output-enable low and the write strobe high. It captures `dram_dq_in` in the last cycle the column strobe is low. `rsp_valid` pulses for one cycle, in the cycle the column strobe returns high, with that byte on `rsp_rdata`.
- R6: A request to the open row keeps the row strobe low. The column strobe falls on the clock edge that accepts the request, and the row strobe does not fall again.
- R7: A request to a different row raises the row strobe, with the column strobe high, for exactly T_RP cycles. The new row's strobe then falls, and the column strobe falls T_RP+T_RCD cycles after acceptance.
- R8: Each column-strobe pulse is low for exactly T_CAS cycles. `dram_addr` is stable during the pulse.
- R9: Every REF_INTERVAL cycles a refresh becomes due. It is a row-only cycle, with the row strobe low for exactly T_RAS cycles and the column strobe high. It uses row addresses 0, 1, 2 and so on, wrapping modulo 2^ROW_W. Any open row is closed first, so the next access reopens its row.
- R10: `req_ready` is low whenever a column strobe is low, a row strobe is low before its first column strobe, or a refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
All strobes are registered, so every result has a fixed distance in cycles from the accepting edge. The column strobe falls 0 cycles after acceptance on an open-row hit, T_RCD on a closed row and T_RP+T_RCD on a row change. Read data follows T_CAS cycles later, in the cycle the column strobe rises. The bench samples everything on the falling clock edge and keeps a cycle counter that advances on the rising edge. Its device model timestamps each strobe edge, and the checks compare those timestamp differences with the exact expected counts. Read data goes through a queue filled at acceptance and emptied by a monitor on each `rsp_valid` pulse.

// File: rtl/pagedram_pkg.sv
package pagedram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ROW,
        ST_CAS,
        ST_CAS_HI,
        ST_REF_RAS,
        ST_REF_PRE
    } pdc_state_e;

endpackage

// File: rtl/pdc_cycle_timer.sv
module pdc_cycle_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pdc_refresh_sched.sv
module pdc_refresh_sched #(
    parameter int INTERVAL = 300,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             due,
    output logic [ROW_W-1:0] row
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             due;
        logic [ROW_W-1:0] row;
    } ref_t;

    ref_t d, q;
    logic tick;

    always_comb begin
        d    = q;
        tick = (q.cnt == CW'(INTERVAL - 1));
        d.cnt = tick ? '0 : q.cnt + 1'b1;
        if (ack) begin
            d.due = 1'b0;
            d.row = q.row + 1'b1;
        end
        if (tick)
            d.due = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign due = q.due;
    assign row = q.row;
endmodule

// File: rtl/pagedram_ctrl.sv
module pagedram_ctrl
    import pagedram_pkg::*;
#(
    parameter int ROW_W        = 9,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int T_RAS        = 4,
    parameter int REF_INTERVAL = 300,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [MUX_W-1:0]  dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int T_MAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX2 = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int TW     = $clog2(T_MAX + 1);

    typedef struct packed {
        pdc_state_e        st;
        logic              for_ref;
        logic              open;
        logic [ROW_W-1:0]  open_row;
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic [MUX_W-1:0]  addr;
        logic [DATA_W-1:0] dq_out;
        logic              dq_oe;
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t d, q;

    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;
    logic             ref_due;
    logic             ref_ack;
    logic [ROW_W-1:0] ref_row;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             row_hit;

    assign req_row = req_addr[ADDR_W-1 -: ROW_W];
    assign req_col = req_addr[COL_W-1:0];
    assign row_hit = q.open && (q.open_row == req_row);

    pdc_cycle_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    pdc_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .due   (ref_due),
        .row   (ref_row)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        ref_ack     = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ref_due) begin
                    if (q.open) begin
                        d.st      = ST_PRECH;
                        d.for_ref = 1'b1;
                        d.ras_n   = 1'b1;
                        d.open    = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(T_RP - 1);
                    end else begin
                        d.st     = ST_REF_RAS;
                        d.ras_n  = 1'b0;
                        d.addr   = MUX_W'(ref_row);
                        ref_ack  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_RAS - 1);
                    end
                end else if (req_valid) begin
                    d.wr    = req_write;
                    d.row   = req_row;
                    d.col   = req_col;
                    d.wdata = req_wdata;
                    if (row_hit) begin
                        d.st     = ST_CAS;
                        d.addr   = MUX_W'(req_col);
                        d.cas_n  = 1'b0;
                        d.we_n   = !req_write;
                        d.oe_n   = req_write;
                        d.dq_oe  = req_write;
                        d.dq_out = req_wdata;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_CAS - 1);
                    end else if (q.open) begin
                        d.st      = ST_PRECH;
                        d.for_ref = 1'b0;
                        d.ras_n   = 1'b1;
                        d.open    = 1'b0;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(T_RP - 1);
                    end else begin
                        d.st       = ST_ROW;
                        d.ras_n    = 1'b0;
                        d.addr     = MUX_W'(req_row);
                        d.open     = 1'b1;
                        d.open_row = req_row;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(T_RCD - 1);
                    end
                end
            end
            ST_PRECH: begin
                if (tmr_done) begin
                    if (q.for_ref) begin
                        d.st     = ST_REF_RAS;
                        d.ras_n  = 1'b0;
                        d.addr   = MUX_W'(ref_row);
                        ref_ack  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_RAS - 1);
                    end else begin
                        d.st       = ST_ROW;
                        d.ras_n    = 1'b0;
                        d.addr     = MUX_W'(q.row);
                        d.open     = 1'b1;
                        d.open_row = q.row;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(T_RCD - 1);
                    end
                end
            end
            ST_ROW: begin
                if (tmr_done) begin
                    d.st     = ST_CAS;
                    d.addr   = MUX_W'(q.col);
                    d.cas_n  = 1'b0;
                    d.we_n   = !q.wr;
                    d.oe_n   = q.wr;
                    d.dq_oe  = q.wr;
                    d.dq_out = q.wdata;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_CAS - 1);
                end
            end
            ST_CAS: begin
                if (tmr_done) begin
                    d.st    = ST_CAS_HI;
                    d.cas_n = 1'b1;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    if (!q.wr) begin
                        d.rsp_valid = 1'b1;
                        d.rdata     = dram_dq_in;
                    end
                end
            end
            ST_CAS_HI: begin
                d.st = ST_IDLE;
            end
            ST_REF_RAS: begin
                if (tmr_done) begin
                    d.st     = ST_REF_PRE;
                    d.ras_n  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_RP - 1);
                end
            end
            ST_REF_PRE: begin
                if (tmr_done)
                    d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.st == ST_IDLE) && !ref_due;
    assign rsp_valid   = q.rsp_valid;
    assign rsp_rdata   = q.rdata;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_addr   = q.addr;
    assign dram_dq_out = q.dq_out;
    assign dram_dq_oe  = q.dq_oe;
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int T_CAS = 2,
    parameter int MUX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [MUX_W-1:0] addr,
    input logic             dq_oe
);
    int unsigned cas_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cas_cnt <= 0;
        else if (!cas_n) cas_cnt <= cas_cnt + 1;
        else            cas_cnt <= 0;
    end

    a_r2_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));

    a_r2_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !cas_n));

    a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !ras_n);

    a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!cas_n && !oe_n));

    a_r7_ras_rise_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(addr));

    a_r8_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> (cas_cnt < T_CAS));

    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cas_n && we_n && oe_n));
endmodule

bind pagedram_ctrl pdc_checker #(.T_CAS(T_CAS), .MUX_W(MUX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .dq_oe     (dram_dq_oe)
);

// File: tb/pagedram_ctrl_tb.sv
module pagedram_ctrl_tb;
    localparam int ROW_W  = 9;
    localparam int COL_W  = 9;
    localparam int DATA_W = 8;
    localparam int T_RCD  = 3;
    localparam int T_CAS  = 2;
    localparam int T_RP   = 3;
    localparam int T_RAS  = 4;
    localparam int REF_IV = 300;
    localparam int ADDR_W = ROW_W + COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [ROW_W-1:0]  addr;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in = '0;

    pagedram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS), .REF_INTERVAL(REF_IV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n),
        .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural device model, evaluated on the falling edge
    logic [DATA_W-1:0] mem [int];
    logic [DATA_W-1:0] shadow [int];
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    logic [ROW_W-1:0] cur_row = '0, cur_col = '0;
    bit cas_since_ras = 0, saw_rise = 0;
    int ras_fall_cyc = 0, ras_rise_cyc = 0, last_cas_fall = 0;
    int opens = 0, last_rcd = 0, last_ras_high = 0, cas_w = 0;
    int ref_cnt = 0, exp_ref_row = 0;
    int ref_row_err = 0, ref_width_err = 0, rp_err = 0, cas_width_err = 0;
    int we_oe_err = 0, bus_err = 0, busy_ready_err = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                last_ras_high = cyc - ras_rise_cyc;
                if (saw_rise && last_ras_high < T_RP) rp_err++;
                ras_fall_cyc  = cyc;
                cur_row       = addr;
                cas_since_ras = 0;
            end
            if (!prev_ras && ras_n) begin
                ras_rise_cyc = cyc;
                saw_rise     = 1;
                if (!cas_since_ras) begin
                    ref_cnt++;
                    if (int'(cur_row) != exp_ref_row) ref_row_err++;
                    exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
                    if (cyc - ras_fall_cyc != T_RAS) ref_width_err++;
                end
            end
            if (prev_cas && !cas_n) begin
                if (!cas_since_ras) begin
                    opens++;
                    last_rcd = cyc - ras_fall_cyc;
                end
                cas_since_ras = 1;
                last_cas_fall = cyc;
                cur_col       = addr;
                cas_w         = 1;
                if (!we_n) begin
                    if (!dq_oe) bus_err++;
                    mem[int'({cur_row, cur_col})] = dq_out;
                end
            end else if (!cas_n) begin
                cas_w++;
            end
            if (!prev_cas && cas_n && cas_w != T_CAS) cas_width_err++;
            if (!cas_n && !oe_n)
                dq_in = mem.exists(int'({cur_row, cur_col})) ? mem[int'({cur_row, cur_col})] : '0;
            else
                dq_in = '0;
            if (!we_n && !oe_n) we_oe_err++;
            if (dq_oe && (we_n || cas_n)) bus_err++;
            if (req_ready && (!cas_n || (!ras_n && !cas_since_ras))) busy_ready_err++;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    // Scoreboard
    logic [DATA_W-1:0] exp_q [$];
    int n_rsp = 0;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_rsp++;
            if (exp_q.size() == 0) begin
                chk(0, "R5", "unexpected rsp_valid", 1, 0);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e, "R5", "read data", int'(rsp_rdata), int'(e));
            end
        end
    end

    task automatic do_req(input bit wr, input int row, input int col,
                          input int data, output int delta);
        int key;
        int acc;
        key = (row << COL_W) | col;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(key);
        req_wdata = DATA_W'(data);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (wr) shadow[key] = DATA_W'(data);
        else    exp_q.push_back(shadow.exists(key) ? shadow[key] : '0);
        @(negedge clk);
        req_valid = 1'b0;
        acc = cyc;
        do @(negedge clk); while (!req_ready);
        delta = last_cas_fall - acc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int dl;
        int opens0;
        int ref0;
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(ras_n && cas_n && we_n && oe_n && !dq_oe && !rsp_valid, "R1",
            "strobes in reset", int'({ras_n, cas_n, we_n, oe_n, dq_oe, rsp_valid}), 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !dq_oe && req_ready, "R1", "after reset",
            int'({ras_n, cas_n, dq_oe, req_ready}), 4'b1101);

        // R3/R4: write on a closed row
        do_req(1, 5, 3, 8'hA5, dl);
        chk(dl == T_RCD, "R3", "closed-row accept to CAS", dl, T_RCD);
        chk(last_rcd == T_RCD, "R3", "RAS fall to CAS fall", last_rcd, T_RCD);
        chk(mem.exists((5 << COL_W) | 3) && mem[(5 << COL_W) | 3] == 8'hA5, "R4",
            "written byte in device", mem.exists((5 << COL_W) | 3) ? int'(mem[(5 << COL_W) | 3]) : -1, 8'hA5);

        // R5/R6: read hit on the open row
        opens0 = opens;
        do_req(0, 5, 3, 0, dl);
        chk(dl == 0, "R6", "hit accept to CAS", dl, 0);
        chk(opens == opens0, "R6", "no new row open on hit", opens - opens0, 0);
        do_req(1, 5, 100, 8'h3C, dl);
        chk(dl == 0, "R6", "hit write accept to CAS", dl, 0);
        do_req(0, 5, 100, 0, dl);
        chk(opens == opens0, "R6", "row kept open across hits", opens - opens0, 0);

        // R7: row change
        do_req(0, 9, 3, 0, dl);
        chk(dl == T_RP + T_RCD, "R7", "miss accept to CAS", dl, T_RP + T_RCD);
        chk(last_ras_high == T_RP, "R7", "precharge width", last_ras_high, T_RP);
        chk(opens == opens0 + 1, "R7", "one new row open", opens - opens0, 1);
        do_req(1, 9, 511, 8'hFF, dl);
        do_req(1, 0, 0, 8'h11, dl);
        do_req(0, 9, 511, 0, dl);
        do_req(0, 0, 0, 0, dl);

        // R9: idle long enough for several refreshes
        ref0 = ref_cnt;
        repeat (4 * REF_IV + 20) @(negedge clk);
        chk(ref_cnt - ref0 >= 3, "R9", "refresh count", ref_cnt - ref0, 3);
        chk(ref_row_err == 0, "R9", "refresh row sequence errors", ref_row_err, 0);
        chk(ref_width_err == 0, "R9", "refresh RAS width errors", ref_width_err, 0);
        opens0 = opens;
        do_req(0, 0, 0, 0, dl);
        chk(opens == opens0 + 1, "R9", "row reopened after refresh", opens - opens0, 1);
        chk(dl == T_RCD, "R9", "closed-row latency after refresh", dl, T_RCD);

        repeat (10) @(negedge clk);
        chk(we_oe_err == 0, "R2", "WE and OE both low", we_oe_err, 0);
        chk(bus_err == 0, "R2", "data drive outside write CAS", bus_err, 0);
        chk(cas_width_err == 0, "R8", "CAS width errors", cas_width_err, 0);
        chk(rp_err == 0, "R7", "RAS high shorter than precharge", rp_err, 0);
        chk(busy_ready_err == 0, "R10", "ready while busy", busy_ready_err, 0);
        chk(n_rsp == 6, "R5", "read responses", n_rsp, 6);
        chk(exp_q.size() == 0, "R5", "outstanding reads", exp_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule